// File: doc/BRIEF.md
# Sectored Flash Controller with Page Buffer

This block connects a small CPU register window to a behavioural 1 KB nonvolatile byte array. The array is split into four 256-byte sectors, and each sector is split into 16-byte pages. Software writes an address and a data byte, then issues a command through the control register. The commands can stage one byte into a 16-byte page buffer, program the staged bytes of one page in a single operation, or erase a byte, a page or a whole sector. Two further commands run a CRC-32 over one sector or over the whole array. The CRC is the only way to verify the contents; the register window has no readback path into the array.

A separate code-read port fetches array bytes for instruction-style reads. Each sector has a lock input. A code read that targets a locked sector is refused and returns zero. Program and erase operations keep the block busy for a fixed, parameterised number of cycles. A command issued while the block is busy is dropped and raises a sticky error flag.

Top module: `sect_flash_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the data and address registers read 0x00, and every array byte reads 0xFF through the code-read port.
- R2: Register index 0 is control on write (bits [2:0] hold the command) and status on read (bit 7 BUSY, bit 6 ERR, other bits 0). Index 1 is data, index 2 is address high (bits [1:0] are array address bits [9:8]) and index 3 is address low. Indices 1 to 3 read back the value last written.
- R3: Command 1 (load) copies the data register into page-buffer slot address-low[3:0] and marks that slot valid. It takes effect at once and never sets BUSY.
- R4: Command 2 (program) targets the page given by address bits [9:4]. It writes only the valid slots, each as old AND buffer byte. When the operation ends, every slot is marked not valid.
- R5: Command 3 erases the addressed byte, command 4 erases its 16-byte page and command 5 erases its 256-byte sector. Each sets exactly that range to 0xFF and leaves all other bytes unchanged.
- R6: A program or erase command keeps BUSY high for exactly OP_CYCLES cycles, counted from the clock edge that accepts the command.
- R7: A nonzero command written while BUSY is ignored and sets ERR on the next cycle. ERR stays set until the next control write that is accepted while idle (command 0 included).
- R8: Command 6 computes the CRC of the sector given by address bits [9:8], and command 7 computes it over all 1024 bytes. The CRC is reflected with polynomial 0xEDB88320, initial value and final XOR both 0xFFFFFFFF, one byte per clock. BUSY stays high for exactly as many cycles as there are bytes, and the result appears on crc_value when BUSY falls.
- R9: When cread_req is high and the lock bit of the sector in cread_addr[9:8] is set, cread_deny is 1 and cread_data is 0x00. When the lock bit is clear, cread_deny is 0 and cread_data is the array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sec_lock | input | 4 | Per-sector lock bits |
| cread_req | input | 1 | Code-read request |
| cread_addr | input | 10 | Code-read byte address |
| cread_data | output | 8 | Code-read byte, zero when refused |
| cread_deny | output | 1 | Code read refused because the sector is locked |
| crc_value | output | 32 | Last completed CRC result |

## Verification
The assertions assume the register window is driven by a single master that writes at most one register per cycle. They also assume OP_CYCLES exceeds the sector size, so that any busy run ends after OP_CYCLES, 256 or 1024 cycles. The bench keeps to these limits: it issues every command with one write strobe, waits for BUSY to fall before starting the next planned operation, and sends extra commands during BUSY only in the scenario that checks the error flag. The lock inputs change only while the block is idle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_LOAD = 3'd1,
        CMD_PROG = 3'd2,
        CMD_ERB  = 3'd3,
        CMD_ERP  = 3'd4,
        CMD_ERS  = 3'd5,
        CMD_CRCS = 3'd6,
        CMD_CRCA = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOD  = 2'd1,
        ST_CRC  = 2'd2
    } fsm_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_AHI  = 2'd2;
    localparam logic [1:0] REG_ALO  = 2'd3;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/sfc_array.sv
module sfc_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [DEPTH];

    // Reset models a blank (erased) part
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/sfc_page_buf.sv
module sfc_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int PW         = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [PW-1:0]                load_idx,
    input  logic [7:0]                   load_data,
    input  logic                         clear,
    output logic [PAGE_BYTES-1:0][7:0]   bytes_o,
    output logic [PAGE_BYTES-1:0]        valid_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] bytes;
        logic [PAGE_BYTES-1:0]      valid;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear) buf_d.valid = '0;
        if (load_en) begin
            buf_d.bytes[load_idx] = load_data;
            buf_d.valid[load_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign bytes_o = buf_q.bytes;
    assign valid_o = buf_q.valid;
endmodule

// File: rtl/sfc_crc8.sv
module sfc_crc8 (
    input  logic [31:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);
    import sfc_pkg::*;

    always_comb begin
        crc_out = crc_in ^ {24'h0, byte_in};
        for (int b = 0; b < 8; b++) begin
            crc_out = crc_out[0] ? ((crc_out >> 1) ^ CRC_POLY) : (crc_out >> 1);
        end
    end
endmodule

// File: rtl/sect_flash_ctrl.sv
module sect_flash_ctrl #(
    parameter int SECT_COUNT = 4,
    parameter int SECT_BYTES = 256,
    parameter int PAGE_BYTES = 16,
    parameter int OP_CYCLES  = 300
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               reg_wr,
    input  logic [1:0]                                         reg_addr,
    input  logic [7:0]                                         reg_wdata,
    output logic [7:0]                                         reg_rdata,
    input  logic [SECT_COUNT-1:0]                              sec_lock,
    input  logic                                               cread_req,
    input  logic [$clog2(SECT_COUNT*SECT_BYTES)-1:0]           cread_addr,
    output logic [7:0]                                         cread_data,
    output logic                                               cread_deny,
    output logic [31:0]                                        crc_value
);
    import sfc_pkg::*;

    localparam int TOTAL = SECT_COUNT * SECT_BYTES;
    localparam int AW    = $clog2(TOTAL);
    localparam int BW    = $clog2(SECT_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int CW    = $clog2(OP_CYCLES);

    typedef struct packed {
        fsm_e          st;
        cmd_e          op;
        logic [AW-1:0] base;
        logic [AW:0]   len;
        logic [AW:0]   idx;
        logic [CW-1:0] cnt;
        logic [31:0]   crc;
        logic [31:0]   crc_out;
        logic          err;
        logic [7:0]    data;
        logic [7:0]    ahi;
        logic [7:0]    alo;
    } state_t;

    state_t s_d, s_q;

    logic [AW-1:0]              walk_addr;
    logic [7:0]                 walk_rd;
    logic                       arr_we;
    logic [7:0]                 arr_wdata;
    logic                       buf_load;
    logic                       buf_clear;
    logic [PAGE_BYTES-1:0][7:0] buf_bytes;
    logic [PAGE_BYTES-1:0]      buf_valid;
    logic [31:0]                crc_next;
    logic [7:0]                 code_byte;
    logic [AW-1:0]              target;
    logic                       busy_w;
    logic                       err_w;
    cmd_e                       cmd_w;

    assign target    = {s_q.ahi, s_q.alo}[AW-1:0];
    assign busy_w    = (s_q.st != ST_IDLE);
    assign err_w     = s_q.err;
    assign cmd_w     = cmd_e'(reg_wdata[2:0]);
    assign walk_addr = s_q.base + s_q.idx[AW-1:0];

    sfc_array #(.DEPTH(TOTAL), .AW(AW)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .waddr   (walk_addr),
        .wdata   (arr_wdata),
        .raddr_a (walk_addr),
        .rdata_a (walk_rd),
        .raddr_b (cread_addr),
        .rdata_b (code_byte)
    );

    sfc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) pbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (buf_load),
        .load_idx  (s_q.alo[PW-1:0]),
        .load_data (s_q.data),
        .clear     (buf_clear),
        .bytes_o   (buf_bytes),
        .valid_o   (buf_valid)
    );

    sfc_crc8 crc_i (
        .crc_in  (s_q.crc),
        .byte_in (walk_rd),
        .crc_out (crc_next)
    );

    always_comb begin
        s_d       = s_q;
        arr_we    = 1'b0;
        arr_wdata = 8'hFF;
        buf_load  = 1'b0;
        buf_clear = 1'b0;

        if (reg_wr) begin
            unique case (reg_addr)
                REG_DATA: s_d.data = reg_wdata;
                REG_AHI:  s_d.ahi  = reg_wdata;
                REG_ALO:  s_d.alo  = reg_wdata;
                default:  ;
            endcase
        end

        // Command acceptance: only while idle; otherwise flag the error
        if (reg_wr && reg_addr == REG_CTRL) begin
            if (busy_w) begin
                if (cmd_w != CMD_NOP) s_d.err = 1'b1;
            end else begin
                s_d.err = 1'b0;
                s_d.op  = cmd_w;
                s_d.idx = '0;
                s_d.cnt = CW'(OP_CYCLES - 1);
                s_d.crc = 32'hFFFF_FFFF;
                unique case (cmd_w)
                    CMD_LOAD: buf_load = 1'b1;
                    CMD_PROG: begin
                        s_d.st   = ST_MOD;
                        s_d.base = {target[AW-1:PW], PW'(0)};
                        s_d.len  = (AW+1)'(PAGE_BYTES);
                    end
                    CMD_ERB: begin
                        s_d.st   = ST_MOD;
                        s_d.base = target;
                        s_d.len  = (AW+1)'(1);
                    end
                    CMD_ERP: begin
                        s_d.st   = ST_MOD;
                        s_d.base = {target[AW-1:PW], PW'(0)};
                        s_d.len  = (AW+1)'(PAGE_BYTES);
                    end
                    CMD_ERS: begin
                        s_d.st   = ST_MOD;
                        s_d.base = {target[AW-1:BW], BW'(0)};
                        s_d.len  = (AW+1)'(SECT_BYTES);
                    end
                    CMD_CRCS: begin
                        s_d.st   = ST_CRC;
                        s_d.base = {target[AW-1:BW], BW'(0)};
                        s_d.len  = (AW+1)'(SECT_BYTES);
                    end
                    CMD_CRCA: begin
                        s_d.st   = ST_CRC;
                        s_d.base = '0;
                        s_d.len  = (AW+1)'(TOTAL);
                    end
                    default: ;
                endcase
            end
        end

        unique case (s_q.st)
            ST_MOD: begin
                // Walk the target range one byte per cycle, then idle out the fixed time
                if (s_q.idx < s_q.len) begin
                    if (s_q.op == CMD_PROG) begin
                        arr_we    = buf_valid[walk_addr[PW-1:0]];
                        arr_wdata = walk_rd & buf_bytes[walk_addr[PW-1:0]];
                    end else begin
                        arr_we    = 1'b1;
                        arr_wdata = 8'hFF;
                    end
                    s_d.idx = s_q.idx + 1'b1;
                end
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                    if (s_q.op == CMD_PROG) buf_clear = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CRC: begin
                s_d.crc = crc_next;
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == s_q.len - 1'b1) begin
                    s_d.st      = ST_IDLE;
                    s_d.crc_out = ~crc_next;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: CMD_NOP, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = {busy_w, s_q.err, 6'b0};
            REG_DATA: reg_rdata = s_q.data;
            REG_AHI:  reg_rdata = s_q.ahi;
            default:  reg_rdata = s_q.alo;
        endcase
    end

    assign cread_deny = cread_req && sec_lock[cread_addr[AW-1:BW]];
    assign cread_data = cread_deny ? 8'h00 : code_byte;
    assign crc_value  = s_q.crc_out;
endmodule

// File: rtl/sect_flash_chk.sv
module sect_flash_chk #(
    parameter int OP_CYCLES  = 300,
    parameter int SECT_BYTES = 256,
    parameter int TOTAL      = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        busy,
    input logic        err,
    input logic        cread_req,
    input logic        cread_deny,
    input logic [7:0]  cread_data,
    input logic [31:0] crc_value
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    logic starts_op;
    assign starts_op = reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] >= 3'd2;

    // R6 / R8: busy runs last the fixed time or one cycle per CRC byte
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(OP_CYCLES) || run_q == 16'(SECT_BYTES) || run_q == 16'(TOTAL)));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !starts_op) |=> !busy);

    a_r3_load_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] == 3'd1) |=> !busy);

    a_r7_err_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] != 3'd0) |=> err);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == 2'd0)) |=> err);

    a_r8_crc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(crc_value));

    a_r9_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cread_deny |-> (cread_data == 8'h00 && cread_req));
endmodule

bind sect_flash_ctrl sect_flash_chk #(
    .OP_CYCLES  (OP_CYCLES),
    .SECT_BYTES (SECT_BYTES),
    .TOTAL      (SECT_COUNT * SECT_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy_w),
    .err        (err_w),
    .cread_req  (cread_req),
    .cread_deny (cread_deny),
    .cread_data (cread_data),
    .crc_value  (crc_value)
);

// File: tb/sect_flash_ctrl_tb_top.sv
module sect_flash_ctrl_tb_top;
    localparam int OPC = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [3:0]  sec_lock = 4'd0;
    logic        cread_req = 1'b0;
    logic [9:0]  cread_addr = 10'd0;
    logic [7:0]  cread_data;
    logic        cread_deny;
    logic [31:0] crc_value;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m [1024];

    always #10 clk = ~clk;

    sect_flash_ctrl #(.OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_lock(sec_lock),
        .cread_req(cread_req), .cread_addr(cread_addr), .cread_data(cread_data),
        .cread_deny(cread_deny), .crc_value(crc_value)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_addr(logic [9:0] a);
        wr(2'd2, {6'd0, a[9:8]});
        wr(2'd3, a[7:0]);
    endtask

    task automatic code_rd(logic [9:0] a, output logic [7:0] d, output logic dn);
        cread_req = 1'b1; cread_addr = a;
        #1;
        d = cread_data; dn = cread_deny;
        cread_req = 1'b0;
    endtask

    task automatic run_cmd(logic [2:0] c, output int n);
        logic [7:0] s;
        wr(2'd0, {5'd0, c});
        n = 0;
        rd(2'd0, s);
        while (s[7]) begin
            @(negedge clk);
            n++;
            rd(2'd0, s);
        end
    endtask

    task automatic load(logic [9:0] a, logic [7:0] d);
        set_addr(a);
        wr(2'd1, d);
        wr(2'd0, 8'd1);
    endtask

    function automatic logic [31:0] ref_crc(int lo, int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'd0, m[lo+i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic cmp_range(string req, int lo, int n);
        logic [7:0] d; logic dn;
        for (int i = lo; i < lo + n; i++) begin
            code_rd(10'(i), d, dn);
            check(req, {24'd0, d}, {24'd0, m[i]});
        end
    endtask

    task automatic t_reset();
        logic [7:0] v; logic dn;
        rd(2'd0, v); check("R1 status", {24'd0, v}, 32'h00);
        rd(2'd1, v); check("R1 data", {24'd0, v}, 32'h00);
        rd(2'd3, v); check("R1 addr lo", {24'd0, v}, 32'h00);
        code_rd(10'h000, v, dn); check("R1 byte 0", {24'd0, v}, 32'hFF);
        code_rd(10'h3FF, v, dn); check("R1 last byte", {24'd0, v}, 32'hFF);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd1, 8'h3C); wr(2'd2, 8'h01); wr(2'd3, 8'h37);
        rd(2'd1, v); check("R2 data readback", {24'd0, v}, 32'h3C);
        rd(2'd2, v); check("R2 addr hi readback", {24'd0, v}, 32'h01);
        rd(2'd3, v); check("R2 addr lo readback", {24'd0, v}, 32'h37);
    endtask

    task automatic t_program();
        logic [7:0] s; int n;
        load(10'h132, 8'h0F);
        rd(2'd0, s); check("R3 load leaves BUSY low", {24'd0, s}, 32'h00);
        load(10'h135, 8'hA5);
        run_cmd(3'd2, n);
        check("R6 program busy cycles", n, OPC);
        m[10'h132] = 8'h0F; m[10'h135] = 8'hA5;
        cmp_range("R4 partial program", 'h130, 16);
        load(10'h132, 8'hF3);
        run_cmd(3'd2, n);
        m[10'h132] = 8'h0F & 8'hF3;
        cmp_range("R4 AND rule", 'h130, 16);
    endtask

    task automatic t_erase();
        int n;
        set_addr(10'h13A);
        run_cmd(3'd4, n);
        check("R6 erase page busy cycles", n, OPC);
        for (int i = 'h130; i < 'h140; i++) m[i] = 8'hFF;
        cmp_range("R5 page erase", 'h130, 16);
        // mask must be clear: only slot 5 is written now
        load(10'h135, 8'h00);
        run_cmd(3'd2, n);
        m[10'h135] = 8'h00;
        cmp_range("R4 mask cleared", 'h130, 16);
        load(10'h0FF, 8'h11); run_cmd(3'd2, n);
        load(10'h100, 8'h22); run_cmd(3'd2, n);
        load(10'h101, 8'h33); run_cmd(3'd2, n);
        m[10'h0FF] = 8'h11; m[10'h100] = 8'h22; m[10'h101] = 8'h33;
        set_addr(10'h100); run_cmd(3'd3, n);
        m[10'h100] = 8'hFF;
        cmp_range("R5 byte erase", 'h0FE, 4);
        set_addr(10'h010); run_cmd(3'd5, n);
        m[10'h0FF] = 8'hFF;
        cmp_range("R5 sector erase edge", 'h0FE, 4);
        cmp_range("R5 page kept", 'h130, 16);
    endtask

    task automatic t_busy_err();
        logic [7:0] s; int n;
        load(10'h250, 8'h12); run_cmd(3'd2, n);
        m[10'h250] = 8'h12;
        set_addr(10'h300);
        wr(2'd0, 8'd5);
        set_addr(10'h250);
        wr(2'd0, 8'd3);
        rd(2'd0, s); check("R7 err while busy", {24'd0, s}, 32'hC0);
        n = 0;
        while (s[7]) begin @(negedge clk); rd(2'd0, s); end
        check("R7 err sticky after idle", {24'd0, s}, 32'h40);
        cmp_range("R7 dropped command", 'h250, 1);
        wr(2'd0, 8'd0);
        rd(2'd0, s); check("R7 err cleared", {24'd0, s}, 32'h00);
    endtask

    task automatic t_crc();
        int n;
        set_addr(10'h180);
        run_cmd(3'd6, n);
        check("R8 sector crc cycles", n, 256);
        check("R8 sector crc value", crc_value, ref_crc(256, 256));
        run_cmd(3'd7, n);
        check("R8 full crc cycles", n, 1024);
        check("R8 full crc value", crc_value, ref_crc(0, 1024));
    endtask

    task automatic t_secure();
        logic [7:0] d; logic dn;
        sec_lock = 4'b0100;
        code_rd(10'h250, d, dn);
        check("R9 locked deny", {31'd0, dn}, 32'd1);
        check("R9 locked data", {24'd0, d}, 32'h00);
        code_rd(10'h135, d, dn);
        check("R9 open deny", {31'd0, dn}, 32'd0);
        check("R9 open data", {24'd0, d}, {24'd0, m[10'h135]});
        sec_lock = 4'b0000;
        code_rd(10'h250, d, dn);
        check("R9 unlocked data", {24'd0, d}, 32'h12);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_program();
        t_erase();
        t_busy_err();
        t_crc();
        t_secure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule